// File: doc/BRIEF.md
# Serial Multiplier with Timed Result Display

This block multiplies two 4-bit unsigned operands with a shift-and-add sequence and shows the result for a fixed window on two BCD digit channels. A start pulse captures the operands. A control unit then runs one add-and-shift step per clock for each multiplier bit. When the last step ends, a ready flag rises and stays high for a display window, which is timed by a free-running prescaler and a 3-bit tick counter. At the end of the window the digit channels show the live operands again.

The high channel normally carries the tens digit and the low channel the units digit. While the result is on display, a hundreds button moves the hundreds digit of the product onto the low channel and blanks the high channel to zero. The prescaler is a chain of four terminal-count dividers followed by a toggle stage. Each divider ratio is a parameter, so a simulation can shrink the window to a few hundred clocks.

Top module: `serial_mult_display`

## Requirements
- R1: While `ready` is low, including during and right after reset, `dig_hi` equals `op_a`, `dig_lo` equals `op_b`, and `show_hund` has no effect.
- R2: While `ready` is high and `show_hund` is low, `dig_hi` is the tens digit and `dig_lo` is the units digit of `op_a*op_b`, where the operands are those captured on the start edge.
- R3: While `ready` is high and `show_hund` is high, `dig_hi` is 0 and `dig_lo` is the hundreds digit of the product.
- R4: A start pulse that is accepted on clock edge E0 makes `ready` rise on edge E0+4, one edge for the load plus four add/shift edges. On edge E0+3 `ready` is still low.
- R5: A start pulse that arrives while a multiply is running, or while `ready` is high, is ignored. The displayed result and the window are unchanged.
- R6: Let T = 2*DIV0*DIV1*DIV2*DIV3 clocks, the tick period. `ready` stays high for at least 7*T and at most 8*T+3 clock cycles.
- R7: After `ready` falls, the channels show the operands again, and a new start pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Start pulse that launches a multiply |
| op_a | input | 4 | Operand A, shown on the high channel when idle |
| op_b | input | 4 | Operand B, shown on the low channel when idle |
| show_hund | input | 1 | Shows the hundreds digit while the result is on display |
| ready | output | 1 | High while the result is on display |
| dig_hi | output | 4 | High BCD digit channel |
| dig_lo | output | 4 | Low BCD digit channel |

## Verification
The bench runs every one of the 256 operand pairs, including 0x0 and 15x15. A datapath that drops a carry out of the accumulator, or that skips or repeats a step, shows a wrong tens or units digit, or a wrong hundreds digit on the three products above 199. Some start pulses land in the middle of a run or inside the window, with different operands driven. A design that restarts on them shows a different product or stretches the window. The bench also measures the window length against the tick period and checks that the operands come back afterwards. An off-by-one tick counter or a timer that never leaves its counting state shows up there.

// File: rtl/smd_pkg.sv
package smd_pkg;

  // Shift register modes: the encoding is part of the register's contract.
  typedef enum logic [1:0] {
    SH_HOLD  = 2'b00,
    SH_LOAD  = 2'b01,
    SH_RIGHT = 2'b10,
    SH_LEFT  = 2'b11
  } sh_mode_e;

  typedef enum logic [1:0] {
    TM_IDLE = 2'b00,
    TM_CLR  = 2'b01,
    TM_CNT  = 2'b10
  } tmr_state_e;

  // 8-bit binary to three BCD digits {hundreds, tens, units} by add-3 shifting.
  function automatic logic [11:0] bin8_to_bcd(input logic [7:0] v);
    logic [19:0] s;
    s = {12'd0, v};
    for (int i = 0; i < 8; i++) begin
      if (s[11:8]  >= 4'd5) s[11:8]  = s[11:8]  + 4'd3;
      if (s[15:12] >= 4'd5) s[15:12] = s[15:12] + 4'd3;
      if (s[19:16] >= 4'd5) s[19:16] = s[19:16] + 4'd3;
      s = s << 1;
    end
    return s[19:8];
  endfunction

endpackage

// File: rtl/smd_shreg.sv
module smd_shreg
  import smd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sh_mode_e     mode,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    unique case (mode)
      SH_LOAD:  q_nxt = din;
      SH_RIGHT: q_nxt = {1'b0, q[W-1:1]};
      SH_LEFT:  q_nxt = {q[W-2:0], 1'b0};
      default:  q_nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/smd_accum.sv
module smd_accum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,   // wins over ld
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (ld)  q <= d;
  end
endmodule

// File: rtl/smd_mult_core.sv
module smd_mult_core
  import smd_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OPW-1:0]   a,
  input  logic [OPW-1:0]   b,
  output logic             busy,
  output logic             done,
  output logic [2*OPW-1:0] prod
);
  localparam int PW = 2 * OPW;
  localparam int CW = (OPW > 1) ? $clog2(OPW) : 1;
  localparam logic [CW-1:0] LAST = CW'(OPW - 1);

  logic          run_q, run_nxt;
  logic [CW-1:0] step_q, step_nxt;
  sh_mode_e      mcand_mode, mplier_mode;
  logic [PW-1:0] mcand;
  logic [OPW-1:0] mplier;
  logic          acc_clr, acc_ld;
  logic [PW-1:0] sum;

  // Control unit: next state
  always_comb begin
    run_nxt     = run_q;
    step_nxt    = step_q;
    mcand_mode  = SH_HOLD;
    mplier_mode = SH_HOLD;
    acc_clr     = 1'b0;
    acc_ld      = 1'b0;
    done        = 1'b0;
    if (!run_q) begin
      if (start) begin
        run_nxt     = 1'b1;
        step_nxt    = '0;
        mcand_mode  = SH_LOAD;
        mplier_mode = SH_LOAD;
        acc_clr     = 1'b1;
      end
    end else begin
      mcand_mode  = SH_LEFT;
      mplier_mode = SH_RIGHT;
      acc_ld      = mplier[0];
      if (step_q == LAST) begin
        run_nxt = 1'b0;
        done    = 1'b1;
      end else begin
        step_nxt = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      step_q <= '0;
    end else begin
      run_q  <= run_nxt;
      step_q <= step_nxt;
    end
  end

  // Datapath
  smd_shreg #(.W(PW)) u_mcand (
    .clk(clk), .rst_n(rst_n), .mode(mcand_mode),
    .din({{OPW{1'b0}}, a}), .q(mcand)
  );

  smd_shreg #(.W(OPW)) u_mplier (
    .clk(clk), .rst_n(rst_n), .mode(mplier_mode), .din(b), .q(mplier)
  );

  assign sum = prod + mcand;

  smd_accum #(.W(PW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .ld(acc_ld), .d(sum), .q(prod)
  );

  assign busy = run_q;
endmodule

// File: rtl/smd_prescaler.sv
module smd_prescaler #(
  parameter int unsigned DIV0 = 50,
  parameter int unsigned DIV1 = 50,
  parameter int unsigned DIV2 = 100,
  parameter int unsigned DIV3 = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int NST = 4;
  localparam int unsigned RATIO [NST] = '{DIV0, DIV1, DIV2, DIV3};

  logic [NST:0] tc;
  logic         tff_q;

  assign tc[0] = 1'b1;

  for (genvar g = 0; g < NST; g++) begin : g_stage
    localparam int unsigned R  = RATIO[g];
    localparam int          SW = (R > 2) ? $clog2(R) : 1;
    localparam logic [SW-1:0] TOP = SW'(R - 1);
    logic [SW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (tc[g]) begin
        if (cnt == TOP)  cnt <= '0;
        else             cnt <= cnt + 1'b1;
      end
    end

    assign tc[g+1] = tc[g] && (cnt == TOP);
  end

  // Toggle stage: a tick on every second terminal count of the last divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tff_q <= 1'b0;
    else if (tc[NST])  tff_q <= ~tff_q;
  end

  assign tick = tc[NST] && tff_q;
endmodule

// File: rtl/smd_disp_timer.sv
module smd_disp_timer
  import smd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic done,
  output logic ready
);
  tmr_state_e st_q, st_nxt;
  logic [2:0] cnt;
  logic       cnt_clr, cnt_en;

  always_comb begin
    st_nxt  = st_q;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    unique case (st_q)
      TM_IDLE: if (done) st_nxt = TM_CLR;
      TM_CLR: begin
        cnt_clr = 1'b1;
        st_nxt  = TM_CNT;
      end
      TM_CNT: begin
        cnt_en = tick;
        if (tick && cnt == 3'd7) st_nxt = TM_IDLE;
      end
      default: st_nxt = TM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TM_IDLE;
    else        st_q <= st_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (cnt_clr) cnt <= '0;
    else if (cnt_en)  cnt <= cnt + 3'd1;
  end

  assign ready = (st_q != TM_IDLE);
endmodule

// File: rtl/serial_mult_display.sv
module serial_mult_display
  import smd_pkg::*;
#(
  parameter int unsigned DIV0 = 50,
  parameter int unsigned DIV1 = 50,
  parameter int unsigned DIV2 = 100,
  parameter int unsigned DIV3 = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] op_a,
  input  logic [3:0] op_b,
  input  logic       show_hund,
  output logic       ready,
  output logic [3:0] dig_hi,
  output logic [3:0] dig_lo
);
  logic [1:0]  rst_sync;
  logic        rst_i_n;
  logic        core_busy, core_done, tick, start_go;
  logic [7:0]  prod;
  logic [11:0] bcd;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  assign start_go = start && !ready && !core_busy;

  smd_mult_core #(.OPW(4)) u_core (
    .clk(clk), .rst_n(rst_i_n), .start(start_go), .a(op_a), .b(op_b),
    .busy(core_busy), .done(core_done), .prod(prod)
  );

  smd_prescaler #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_pre (
    .clk(clk), .rst_n(rst_i_n), .tick(tick)
  );

  smd_disp_timer u_tmr (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .done(core_done), .ready(ready)
  );

  assign bcd = bin8_to_bcd(prod);

  always_comb begin
    if (!ready) begin
      dig_hi = op_a;
      dig_lo = op_b;
    end else if (show_hund) begin
      dig_hi = 4'd0;
      dig_lo = bcd[11:8];
    end else begin
      dig_hi = bcd[7:4];
      dig_lo = bcd[3:0];
    end
  end
endmodule

// File: rtl/smd_checker.sv
module smd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       ready,
  input logic       show_hund,
  input logic [3:0] op_a,
  input logic [3:0] op_b,
  input logic [3:0] dig_hi,
  input logic [3:0] dig_lo
);
  logic [2:0] lat;

  // Edges since the last accepted start, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lat <= '0;
    else if (start && !ready && !busy)   lat <= 3'd1;
    else if (lat != 3'd0 && lat != 3'd7) lat <= lat + 3'd1;
  end

  // R1: operands shown while not ready
  a_r1_idle_shows_ops: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (dig_hi == op_a && dig_lo == op_b));

  // R2: result channels always hold decimal digits
  a_r2_digits_decimal: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (dig_hi <= 4'd9 && dig_lo <= 4'd9));

  // R3: hundreds view blanks the high channel
  a_r3_hund_blank_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && show_hund) |-> dig_hi == 4'd0);

  // R4: ready rises on the fourth edge after the load edge (lat counted 5 by then)
  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> lat == 3'd5);

  // R5: result held steady during the window
  a_r5_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready) && $stable(show_hund)) |-> ($stable(dig_hi) && $stable(dig_lo)));

  // R6: window lasts more than one cycle
  a_r6_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |=> ready);
endmodule

bind serial_mult_display smd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(core_busy), .ready(ready),
  .show_hund(show_hund), .op_a(op_a), .op_b(op_b), .dig_hi(dig_hi), .dig_lo(dig_lo)
);

// File: tb/serial_mult_display_bench.sv
`timescale 1ns/1ps
module serial_mult_display_bench;
  localparam int unsigned D = 2;
  localparam int TP   = 2 * D * D * D * D;
  localparam int WMIN = 7 * TP;
  localparam int WMAX = 8 * TP + 3;

  logic       clk = 1'b0;
  logic       rst_n, start, show_hund;
  logic [3:0] op_a, op_b;
  logic       ready;
  logic [3:0] dig_hi, dig_lo;

  int checks = 0;
  int errors = 0;
  int hi_cnt;
  bit finished = 0;

  always #5 clk = ~clk;

  serial_mult_display #(.DIV0(D), .DIV1(D), .DIV2(D), .DIV3(D)) u_serial_mult_display (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .show_hund(show_hund), .ready(ready), .dig_hi(dig_hi), .dig_lo(dig_lo)
  );

  // Window length counter, bench side
  always @(posedge clk) begin
    if (start && !ready) hi_cnt <= 0;
    else if (ready)      hi_cnt <= hi_cnt + 1;
  end

  function automatic logic [3:0] dec_digit(input int v, input int pos);
    int p;
    p = v;
    for (int i = 0; i < pos; i++) p = p / 10;
    return 4'(p % 10);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic run_pair(input logic [3:0] a, input logic [3:0] b, input bit hund_first,
                          input bit poke_run, input bit poke_win);
    int p, wait_n;
    p = int'(a) * int'(b);
    op_a = a; op_b = b; show_hund = hund_first;
    @(negedge clk);
    chk("R1 idle high channel", dig_hi, a);
    chk("R1 idle low channel", dig_lo, b);
    start = 1'b1;
    @(negedge clk);                // after load edge E0
    start = 1'b0;
    @(negedge clk);                // after E1
    if (poke_run) begin            // R5: start during a run
      op_a = ~a; op_b = ~b; start = 1'b1;
    end
    @(negedge clk);                // after E2
    start = 1'b0; op_a = a; op_b = b;
    @(negedge clk);                // after E3
    chk("R4 ready low before last step", ready, 0);
    @(negedge clk);                // after E4
    chk("R4 ready high after last step", ready, 1);
    show_hund = 1'b0;
    @(negedge clk);
    chk("R2 tens", dig_hi, dec_digit(p, 1));
    chk("R2 units", dig_lo, dec_digit(p, 0));
    show_hund = 1'b1;
    @(negedge clk);
    chk("R3 hundreds on low", dig_lo, dec_digit(p, 2));
    chk("R3 high blanked", dig_hi, 0);
    show_hund = 1'b0;
    if (poke_win) begin            // R5: start during the window
      op_a = ~a; op_b = ~b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk("R5 ready kept", ready, 1);
      chk("R5 tens kept", dig_hi, dec_digit(p, 1));
      chk("R5 units kept", dig_lo, dec_digit(p, 0));
      op_a = a; op_b = b;
    end
    wait_n = 0;
    while (ready && wait_n < 1000) begin
      @(negedge clk);
      wait_n++;
    end
    chk("R6 window ended", ready, 0);
    chk_range("R6 window length", hi_cnt, WMIN, WMAX);
    show_hund = 1'b1;
    @(negedge clk);
    chk("R7 operands back high", dig_hi, a);
    chk("R7 operands back low, hund ignored", dig_lo, b);
    show_hund = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst_n = 1'b0; start = 1'b0; show_hund = 1'b1;
    op_a = 4'd9; op_b = 4'd6; hi_cnt = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", ready, 0);
    chk("R1 reset high channel", dig_hi, 9);
    chk("R1 reset low channel", dig_lo, 6);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    show_hund = 1'b0;
    // directed corners
    run_pair(4'd15, 4'd15, 1'b0, 1'b1, 1'b1);
    run_pair(4'd0,  4'd0,  1'b1, 1'b0, 1'b0);
    run_pair(4'd14, 4'd15, 1'b0, 1'b1, 1'b1);
    // exhaustive sweep with random pokes
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run_pair(4'(a), 4'(b), 1'($urandom % 2), ($urandom % 4) == 0, ($urandom % 4) == 0);
      end
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule